// File: doc/BRIEF.md
# Serial Character Receiver with Per-Entry Error Tags

This block takes an asynchronous serial line and turns it into characters. It oversamples the line at sixteen ticks per bit, confirms each start bit at mid-bit, and samples each data, parity and stop bit at the centre of its period. Every finished character is written into a receive FIFO along with its own framing, parity and break flags. A flag therefore stays attached to the character it arrived with, and it is seen when that character reaches the head of the FIFO.

Software-style access goes through a read port that shows the oldest entry as one 32-bit word. A one-cycle `rd_en` pulse removes that entry. Two conditions are handled specially. A line held low for a whole character produces exactly one zero character marked as a break, and reception then waits for the line to go high and for a new start bit. A character that finishes while the FIFO is full is dropped, and this sets a sticky overrun indication. A one-cycle `err_clr` pulse clears the sticky overrun and the sticky error summary.

Top module: `uart_rx_tagged`

## Requirements
- R1: The read word holds the head character in bits 7:0, its framing flag in bit 8, its parity flag in bit 9, its break flag in bit 10 and the sticky overrun in bit 11. Bits 31:12 are always zero. The whole word is zero while the FIFO is empty.
- R2: A high `rd_en` with a non-empty FIFO removes the oldest entry, so characters come out in arrival order. A high `rd_en` with an empty FIFO changes nothing.
- R3: The oversampling tick fires once every `baud_div`+1 clocks, and one bit lasts 16 ticks. A falling edge starts a frame only if the line is still low 8 ticks later. A shorter low pulse is ignored.
- R4: Data arrives least significant bit first. `data_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper data bits read as zero.
- R5: When `par_en` is 1, one parity bit follows the data. `par_odd`=0 requires an even count of ones over data plus parity, and `par_odd`=1 requires an odd count. A mismatch sets bit 9 and the character is still stored. When `par_en` is 0, no parity bit is expected.
- R6: A low stop bit on a frame that is not a break sets bit 8, and the data is still stored.
- R7: A frame whose every sample is low (start, data, parity if enabled, and stop) stores one entry with data 0 and bit 10 set. Bits 8 and 9 are clear in that entry.
- R8: After a break, no character is accepted while the line stays low. Reception resumes only after the line goes high and a new start bit is confirmed.
- R9: A character that completes while the FIFO is full is discarded, and the stored entries are kept. The overrun indication (read-word bit 11 and `err_flags[3]`) then stays set until `err_clr`.
- R10: `err_flags` gathers stored-entry errors as {overrun, break, parity, framing} in bits 3..0. An `err_clr` pulse clears all four bits. A new error in the same cycle as `err_clr` takes priority over the clear.
- R11: A character's entry becomes readable within one stop-bit period of the line entering the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | DIV_W | Oversampling tick period minus one, in clocks |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| data_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Pop the head entry |
| err_clr | input | 1 | Clear sticky overrun and error summary |
| rd_data | output | 32 | Head entry word (layout in R1) |
| rx_empty | output | 1 | FIFO holds no entry |
| rx_full | output | 1 | FIFO holds DEPTH entries |
| err_flags | output | 4 | Sticky {overrun, break, parity, framing} |

## Verification
With `baud_div` at 0, the line passes two synchronizer flops and one detect cycle. The stop bit is therefore sampled about 10.5 clocks after it starts on the line. The entry is written one clock later, so `rx_empty` drops about 11.5 clocks into the stop bit. The bench takes each frame's result at the end of the 16-clock stop bit and requires the monitor to have matched it by then. A popped entry is replaced at the next clock edge. The monitor pops only on every other falling edge, so each word it compares is stable. Overrun, flag and emptiness checks are taken at falling edges once the line has been idle for at least two bit times.

// File: rtl/uart_rx_pkg.sv
// Shared types for the tagged serial receiver.
// Assumes: characters are at most 8 bits; flags travel with each entry.
package uart_rx_pkg;

    // One FIFO entry: character plus the flags it arrived with.
    typedef struct packed {
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
    localparam int WORD_W  = 32;

    // Receive sequencer states.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

endpackage

// File: rtl/uart_rx_baud.sv
// Oversampling tick generator: one-clock tick every div+1 clocks.
// Assumes div changes only while the receiver is idle.
module uart_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    // Count clocks and restart on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_rx_sync.sv
// Multi-flop synchronizer for the asynchronous line; resets to idle (1).
// Assumes STAGES >= 2.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Frame sequencer: confirms start at mid-bit, samples LSB-first data,
// optional parity and stop at bit centres, and classifies the frame.
// Emits a one-clock push with an entry carrying its own error flags.
// After a break it holds until the line is seen high again.
// Assumes 16 ticks per bit; config inputs are stable during a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] data_len,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       push,
    output rx_entry_t  entry
);
    localparam logic [3:0] MID_TICK  = 4'd7;
    localparam logic [3:0] LAST_TICK = 4'd15;

    rx_state_t  state_q;
    logic [3:0] tcnt_q;
    logic [2:0] bidx_q;
    logic [7:0] shreg_q;
    logic       par_bit_q;
    logic       any_one_q;
    logic       push_q;
    rx_entry_t  entry_q;

    logic [3:0] nbits;
    logic [7:0] aligned;
    logic       par_bad;
    logic       is_brk;

    assign nbits   = {2'b00, data_len} + 4'd5;
    assign aligned = shreg_q >> (4'd8 - nbits);
    assign par_bad = ((^aligned) ^ par_bit_q) != par_odd;
    assign is_brk  = !rx_s && !any_one_q;

    // Advance the frame state on oversampling ticks and build entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            tcnt_q    <= '0;
            bidx_q    <= '0;
            shreg_q   <= '0;
            par_bit_q <= 1'b0;
            any_one_q <= 1'b0;
            push_q    <= 1'b0;
            entry_q   <= '0;
        end else begin
            push_q <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state_q <= RX_START;
                            tcnt_q  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt_q == MID_TICK) begin
                            tcnt_q <= '0;
                            if (!rx_s) begin
                                state_q   <= RX_DATA;
                                bidx_q    <= '0;
                                shreg_q   <= '0;
                                par_bit_q <= 1'b0;
                                any_one_q <= 1'b0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt_q == LAST_TICK) begin
                            tcnt_q    <= '0;
                            shreg_q   <= {rx_s, shreg_q[7:1]};
                            any_one_q <= any_one_q | rx_s;
                            if ({1'b0, bidx_q} == nbits - 4'd1)
                                state_q <= par_en ? RX_PARITY : RX_STOP;
                            else
                                bidx_q <= bidx_q + 1'b1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (tcnt_q == LAST_TICK) begin
                            tcnt_q    <= '0;
                            par_bit_q <= rx_s;
                            any_one_q <= any_one_q | rx_s;
                            state_q   <= RX_STOP;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt_q == LAST_TICK) begin
                            tcnt_q       <= '0;
                            push_q       <= 1'b1;
                            entry_q.brk  <= is_brk;
                            entry_q.frm  <= !rx_s && !is_brk;
                            entry_q.par  <= par_en && !is_brk && par_bad;
                            entry_q.data <= is_brk ? 8'h00 : aligned;
                            state_q      <= is_brk ? RX_HOLD : RX_IDLE;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_HOLD: begin
                        if (rx_s) state_q <= RX_IDLE;
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign push  = push_q;
    assign entry = entry_q;

    // While held after a break, no further entry may be produced.
    assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HOLD && $past(state_q) == RX_HOLD) |-> !push_q);

    // A break entry is all-zero data with only the break flag set (R7).
    assert_break_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_q && entry_q.brk) |-> (entry_q.data == 8'h00 && !entry_q.frm && !entry_q.par
                                     && state_q == RX_HOLD));

    // Each completed frame yields a single one-clock push.
    assert_push_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push_q |=> !push_q);
endmodule

// File: rtl/uart_rx_fifo.sv
// Show-ahead FIFO: head entry is visible combinationally, pop on rd_en.
// Assumes the caller never writes when full nor reads when empty.
module uart_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   count_q;

    assign empty   = (count_q == '0);
    assign full    = (count_q == (AW+1)'(DEPTH));
    assign rd_data = mem_q[rptr_q];

    // Store the written entry at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wptr_q] <= wr_data;
    end

    // Move pointers and occupancy on writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (wr_en) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (rd_en) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            if (wr_en && !rd_en)      count_q <= count_q + 1'b1;
            else if (!wr_en && rd_en) count_q <= count_q - 1'b1;
        end
    end

    assert_no_write_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    assert_no_read_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/uart_rx_tagged.sv
// Top: synchronizer, tick generator, frame sequencer and tagged FIFO.
// Owns the sticky overrun and error summary and forms the read word.
// Assumes rd_en and err_clr are single-clock strobes.
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              rx_in,
    input  logic [1:0]        data_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_en,
    input  logic              err_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rx_empty,
    output logic              rx_full,
    output logic [3:0]        err_flags
);
    logic      rx_s, tick, f_push, wr, pop, ovr_q;
    logic [2:0] sticky_q;
    rx_entry_t f_entry, head;
    logic [ENTRY_W-1:0] head_raw;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
        .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
        .push(f_push), .entry(f_entry)
    );

    assign wr  = f_push && !rx_full;
    assign pop = rd_en && !rx_empty;

    uart_rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(f_entry),
        .rd_en(pop), .rd_data(head_raw), .empty(rx_empty), .full(rx_full)
    );

    assign head = rx_entry_t'(head_raw);

    // Sticky overrun and error summary; a new event outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q    <= 1'b0;
            sticky_q <= '0;
        end else begin
            ovr_q    <= (f_push && rx_full) || (ovr_q && !err_clr);
            sticky_q <= (err_clr ? 3'b000 : sticky_q)
                        | ({f_entry.brk, f_entry.par, f_entry.frm} & {3{wr}});
        end
    end

    assign err_flags = {ovr_q, sticky_q};

    // Read word: zero when empty, else head entry with overrun in bit 11.
    always_comb begin
        rd_data = '0;
        if (!rx_empty)
            rd_data[11:0] = {ovr_q, head.brk, head.par, head.frm, head.data};
    end

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovr_q) && !$past(err_clr)) |-> ovr_q);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_clr) && !$past(f_push)) |-> (err_flags == 4'b0000));

    assert_empty_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (rd_data == '0));
endmodule

// File: tb/sim_uart_rx_tagged.sv
module sim_uart_rx_tagged;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int BIT_CLKS   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = '0;
    logic        rx_in = 1'b1;
    logic [1:0]  data_len = 2'd3;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        rd_en = 1'b0;
    logic        err_clr = 1'b0;
    logic [31:0] rd_data;
    logic        rx_empty, rx_full;
    logic [3:0]  err_flags;

    int checks = 0, errors = 0, sent = 0, got = 0;
    bit reads_on = 1'b1;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    uart_rx_tagged #(.DIV_W(16), .DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_in(rx_in),
        .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
        .rd_en(rd_en), .err_clr(err_clr), .rd_data(rd_data),
        .rx_empty(rx_empty), .rx_full(rx_full), .err_flags(err_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic ovr, input logic be, input logic pe,
                                         input logic fe, input logic [7:0] d);
        return {20'b0, ovr, be, pe, fe, d};
    endfunction

    task automatic expect_word(input logic [31:0] w, input string req);
        exp_q.push_back(w);
        tag_q.push_back(req);
        sent++;
    endtask

    task automatic hold_line(input logic v, input int clks);
        rx_in = v;
        repeat (clks) @(negedge clk);
    endtask

    // Drive one frame; stop_v selects the stop level, flip corrupts parity.
    task automatic send(input logic [7:0] d, input bit flip, input logic stop_v);
        int nb;
        logic p;
        nb = int'(data_len) + 5;
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < nb; i++) hold_line(d[i], BIT_CLKS);
        if (par_en) begin
            p = ^(d & 8'((1 << nb) - 1));
            p = p ^ par_odd ^ flip;
            hold_line(p, BIT_CLKS);
        end
        hold_line(stop_v, BIT_CLKS);
        if (reads_on) chk("R11 entry read by end of stop bit", got, sent);
        hold_line(1'b1, 2*BIT_CLKS);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare head entries against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) begin
                rd_en = 1'b0;
            end else if (reads_on && !rx_empty && rst_n) begin
                if (exp_q.size() == 0) begin
                    errors++; checks++;
                    $display("FAIL R2 unexpected entry: actual %h expected none", rd_data);
                end else begin
                    string t;
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, rd_data, e);
                end
                got++;
                rd_en = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset empty", {31'b0, rx_empty}, 32'd1);
        chk("R10 reset flags", {28'b0, err_flags}, 32'h0);
        rst_n = 1'b1;
        hold_line(1'b1, 4*BIT_CLKS);

        // 8-bit frames, no parity (R4, R1).
        expect_word(word(0,0,0,0,8'hA5), "R4 data A5"); send(8'hA5, 0, 1'b1);
        expect_word(word(0,0,0,0,8'h3C), "R4 data 3C"); send(8'h3C, 0, 1'b1);
        expect_word(word(0,0,0,0,8'hFF), "R1 data FF"); send(8'hFF, 0, 1'b1);
        expect_word(word(0,0,0,0,8'h00), "R7 zero with good stop is no break"); send(8'h00, 0, 1'b1);

        // 5-bit frames (R4).
        data_len = 2'd0;
        expect_word(word(0,0,0,0,8'h15), "R4 5-bit 15"); send(8'h15, 0, 1'b1);
        expect_word(word(0,0,0,0,8'h13), "R4 5-bit upper zero"); send(8'hF3, 0, 1'b1);

        // 7-bit with parity (R5).
        data_len = 2'd2; par_en = 1'b1; par_odd = 1'b0;
        expect_word(word(0,0,0,0,8'h55), "R5 even good"); send(8'h55, 0, 1'b1);
        expect_word(word(0,0,1,0,8'h55), "R5 even bad"); send(8'h55, 1, 1'b1);
        par_odd = 1'b1;
        expect_word(word(0,0,0,0,8'h41), "R5 odd good"); send(8'h41, 0, 1'b1);
        expect_word(word(0,0,1,0,8'h41), "R5 odd bad"); send(8'h41, 1, 1'b1);

        // Framing error (R6).
        data_len = 2'd3; par_en = 1'b0;
        expect_word(word(0,0,0,1,8'h81), "R6 low stop"); send(8'h81, 0, 1'b0);

        // Short low glitch (R3).
        hold_line(1'b0, 4);
        hold_line(1'b1, 4*BIT_CLKS);
        chk("R3 glitch ignored empty", {31'b0, rx_empty}, 32'd1);
        chk("R3 glitch no entry", got, sent);

        chk("R10 sticky flags", {28'b0, err_flags}, 32'h3);
        pulse_clr();
        chk("R10 cleared", {28'b0, err_flags}, 32'h0);

        // Break, held low well past detection (R7, R8).
        expect_word(word(0,1,0,0,8'h00), "R7 single break entry");
        hold_line(1'b0, 14*BIT_CLKS);
        chk("R8 one entry while held low", got, sent);
        hold_line(1'b1, 2*BIT_CLKS);
        chk("R8 still one entry after idle", got, sent);
        chk("R10 break flag", {28'b0, err_flags}, 32'h4);
        expect_word(word(0,0,0,0,8'h5A), "R8 resumes after idle and start"); send(8'h5A, 0, 1'b1);
        pulse_clr();

        // Overrun (R9).
        reads_on = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            expect_word(word(1,0,0,0,8'(8'h10 + i)), "R9 kept entry with overrun");
            send(8'(8'h10 + i), 0, 1'b1);
        end
        send(8'hEE, 0, 1'b1);
        chk("R9 full", {31'b0, rx_full}, 32'd1);
        chk("R9 overrun sticky", {28'b0, err_flags}, 32'h8);
        reads_on = 1'b1;
        repeat (4*DEPTH) @(negedge clk);
        chk("R9 drained kept entries only", got, sent);
        chk("R9 overrun holds until clear", {28'b0, err_flags}, 32'h8);
        pulse_clr();
        chk("R9 overrun cleared", {28'b0, err_flags}, 32'h0);

        // rd_en on empty (R2).
        reads_on = 1'b0;
        repeat (2) @(negedge clk);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R2 empty pop no effect", {31'b0, rx_empty}, 32'd1);
        chk("R2 empty word", rd_data, 32'h0);
        reads_on = 1'b1;
        expect_word(word(0,0,0,0,8'hC3), "R2 order after empty pop"); send(8'hC3, 0, 1'b1);
        expect_word(word(0,0,0,0,8'h96), "R2 order second"); send(8'h96, 0, 1'b1);

        repeat (8) @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule